// File: doc/BRIEF.md
# PLL Configuration and Lock-Loss Monitor

This block holds the setup fields for an on-chip high-speed frequency synthesizer and watches its lock indicator. Software programs a 6-bit feedback multiplier and an input-band select through a small word-addressed register bus. Both fields are driven straight to the analog PLL. The synthesizer output frequency is the reference frequency times (multiplier + 1). Downstream logic receives half of that rate, so that the duty cycle is even. The band select is 0 for a reference at or below 6 MHz and 1 for a reference above 6 MHz.

The PLL's lock line is asynchronous. It is brought into the clock domain and shown as a status bit that reads 1 only while the PLL is on frequency and stable. When lock is lost after the PLL has locked, the block sets a sticky raw flag. Software clears the flag by writing 1 to a separate clear word. A mask bit decides whether the flag reaches the interrupt line. While the subsystem power input is high, the configuration fields are frozen, because the PLL must not be retuned while it runs.

Register map (word addresses):

| Address | Contents |
| --- | --- |
| 0 | Configuration: multiplier in [5:0], band select in [8], lock status in [16] (read-only) |
| 1 | Raw status: unlock flag in [0] |
| 2 | Mask: interrupt enable in [0] |
| 3 | Clear: write-only, reads as 0 |

Top module: `pll_ctl_unit`

## Requirements
- R1: After a synchronous reset, the following are all 0: the multiplier, the band select, the unlock flag, the mask, the interrupt line and every register readback.
- R2: While `pwr_on` is low, a write to address 0 loads the multiplier from bits [5:0] and the band select from bit 8. Both then appear on `mult_o`/`range_hi_o` and in the readback of address 0.
- R3: While `pwr_on` is high, writes to address 0 are ignored. The multiplier and the band select keep their previous values.
- R4: Bit 16 of address 0 reflects `lock_async` after a two-flop synchronizer. It reads 1 no later than four cycles after the input rises.
- R5: The unlock flag (address 1, bit 0) is set only by a 1-to-0 transition of the synchronized lock while `pwr_on` is high and lock has been high since power was applied. A lock level held low does not set it. A transition while power is off does not set it.
- R6: The unlock flag is sticky. Writing 1 to bit 0 of address 3 clears it, and writing 0 there has no effect. When a new event and a clear fall in the same cycle, the event wins. Address 3 reads as 0.
- R7: `irq_o` is a registered copy of (flag AND mask), where the mask is bit 0 of address 2. With the mask at 0, the flag still sets but `irq_o` stays low.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data valid on `bus_rdata` after the next edge |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pwr_on | input | 1 | Subsystem powered; freezes configuration and enables lock monitoring |
| lock_async | input | 1 | Asynchronous lock indicator from the PLL |
| mult_o | output | 6 | Feedback multiplier to the PLL |
| range_hi_o | output | 1 | Input band select to the PLL |
| irq_o | output | 1 | Masked unlock interrupt |

## Verification
The assertions rely on the following about the inputs:
- A read and a write never target the clear word in a way that has to be ordered against reset.
- `pwr_on` changes only on clock edges.
- The lock input stays steady long enough to pass the synchronizer, so each level lasts several cycles and no edge is lost.

The stimulus holds every lock level for at least four cycles and changes `pwr_on` only between bus accesses. It places each readback after the full synchronizer and flag latency has elapsed.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 32;
  localparam int MULT_W  = 6;
  localparam int RANGE_B = 8;
  localparam int LOCK_B  = 16;

  localparam logic [ADDR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] A_RAW  = 2'd1;
  localparam logic [ADDR_W-1:0] A_MASK = 2'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 2'd3;
endpackage

// File: rtl/pll_ctl_sync.sv
module pll_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_async;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_async};
      end
    end
  endgenerate

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pll_ctl_cfg.sv
module pll_ctl_cfg #(
  parameter int MULT_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              frozen,
  input  logic [MULT_W-1:0] mult_in,
  input  logic              range_in,
  output logic [MULT_W-1:0] mult_q,
  output logic              range_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mult_q  <= '0;
      range_q <= 1'b0;
    end else if (wr_en && !frozen) begin
      mult_q  <= mult_in;
      range_q <= range_in;
    end
  end
endmodule

// File: rtl/pll_ctl_unlock_det.sv
module pll_ctl_unlock_det (
  input  logic clk,
  input  logic rst,
  input  logic pwr_on,
  input  logic lock_s,
  output logic evt
);
  logic prev_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      prev_q <= lock_s;
      if (!pwr_on)     armed_q <= 1'b0;
      else if (lock_s) armed_q <= 1'b1;
    end
  end

  assign evt = pwr_on && armed_q && prev_q && !lock_s;
endmodule

// File: rtl/pll_ctl_unit.sv
module pll_ctl_unit
  import pll_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pwr_on,
  input  logic              lock_async,
  output logic [MULT_W-1:0] mult_o,
  output logic              range_hi_o,
  output logic              irq_o
);
  logic lock_s;
  logic unlock_evt;
  logic flag_q;
  logic mask_q;
  logic clr_hit;
  logic cfg_wr;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata;
  assign cfg_wr  = bus_wr && (bus_addr == A_CFG);
  assign clr_hit = bus_wr && (bus_addr == A_CLR) && bus_wdata[0];

  pll_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_async(lock_async), .q_sync(lock_s)
  );

  pll_ctl_cfg #(.MULT_W(MULT_W)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .frozen(pwr_on),
    .mult_in(bus_wdata[MULT_W-1:0]), .range_in(bus_wdata[RANGE_B]),
    .mult_q(mult_o), .range_q(range_hi_o)
  );

  pll_ctl_unlock_det u_det (
    .clk(clk), .rst(rst), .pwr_on(pwr_on), .lock_s(lock_s), .evt(unlock_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      mask_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      if (unlock_evt)   flag_q <= 1'b1;
      else if (clr_hit) flag_q <= 1'b0;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[0];
      irq_o <= flag_q && mask_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      case (bus_addr)
        A_CFG: begin
          bus_rdata[MULT_W-1:0] <= mult_o;
          bus_rdata[RANGE_B]    <= range_hi_o;
          bus_rdata[LOCK_B]     <= lock_s;
        end
        A_RAW:   bus_rdata[0] <= flag_q;
        A_MASK:  bus_rdata[0] <= mask_q;
        default: bus_rdata    <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pll_ctl_unit_chk.sv
module pll_ctl_unit_chk
  import pll_ctl_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              pwr_on,
  input logic [MULT_W-1:0] mult_o,
  input logic              range_hi_o,
  input logic              irq_o,
  input logic              flag_q,
  input logic              mask_q,
  input logic              unlock_evt,
  input logic              clr_hit
);
  p_cfg_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    pwr_on |=> ($stable(mult_o) && $stable(range_hi_o)));

  p_flag_cause_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(unlock_evt));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_hit && !unlock_evt) |=> !flag_q);

  p_irq_gate_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(flag_q && mask_q));
endmodule

bind pll_ctl_unit pll_ctl_unit_chk u_chk (
  .clk(clk), .rst(rst), .pwr_on(pwr_on), .mult_o(mult_o),
  .range_hi_o(range_hi_o), .irq_o(irq_o), .flag_q(flag_q),
  .mask_q(mask_q), .unlock_evt(unlock_evt), .clr_hit(clr_hit)
);

// File: tb/pll_ctl_unit_bench.sv
module pll_ctl_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwr_on = 1'b0;
  logic        lock_async = 1'b0;
  logic [5:0]  mult_o;
  logic        range_hi_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  logic rd_seen = 1'b0;

  typedef struct { logic [31:0] val; int req; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  pll_ctl_unit u_pll_ctl_unit (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwr_on(pwr_on), .lock_async(lock_async), .mult_o(mult_o),
    .range_hi_o(range_hi_o), .irq_o(irq_o)
  );

  always @(posedge clk) rd_seen <= bus_rd;

  // monitor: pops expected readback when a read has completed
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (bus_rdata !== e.val) begin
        fails++;
        $display("FAIL R%0d readback got %h exp %h", e.req, bus_rdata, e.val);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input int req);
    exp_t x;
    x.val = e; x.req = req;
    exp_q.push_back(x);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk(input int req, input logic [31:0] got, input logic [31:0] e);
    checks++;
    if (got !== e) begin
      fails++;
      $display("FAIL R%0d port got %h exp %h", req, got, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(5);
    rst = 1'b0;
    cyc(1);
    // R1: reset state
    chk(1, {26'd0, mult_o}, 32'h0);
    chk(1, {31'd0, range_hi_o}, 32'h0);
    chk(1, {31'd0, irq_o}, 32'h0);
    rd(2'd0, 32'h0, 1);
    rd(2'd1, 32'h0, 1);
    rd(2'd2, 32'h0, 1);

    // R2: configuration while unpowered
    wr(2'd0, 32'h0000_0113);
    rd(2'd0, 32'h0000_0113, 2);
    chk(2, {26'd0, mult_o}, 32'h13);
    chk(2, {31'd0, range_hi_o}, 32'h1);

    // R3: frozen while powered
    pwr_on = 1'b1;
    cyc(1);
    wr(2'd0, 32'h0000_0005);
    rd(2'd0, 32'h0000_0113, 3);
    chk(3, {26'd0, mult_o}, 32'h13);

    // R5: lock held low while powered gives no flag
    cyc(6);
    rd(2'd1, 32'h0, 5);

    // R4: lock status through synchronizer
    lock_async = 1'b1;
    cyc(4);
    rd(2'd0, 32'h0001_0113, 4);

    // R7: mask on, then lose lock
    wr(2'd2, 32'h1);
    rd(2'd2, 32'h1, 7);
    lock_async = 1'b0;
    cyc(5);
    rd(2'd1, 32'h1, 5);
    rd(2'd0, 32'h0000_0113, 4);
    chk(7, {31'd0, irq_o}, 32'h1);

    // R6: writing 0 to clear has no effect, 1 clears
    wr(2'd3, 32'h0);
    rd(2'd1, 32'h1, 6);
    wr(2'd3, 32'h1);
    rd(2'd1, 32'h0, 6);
    cyc(1);
    chk(7, {31'd0, irq_o}, 32'h0);
    rd(2'd3, 32'h0, 6);

    // R7: mask off, flag sets, irq stays low
    wr(2'd2, 32'h0);
    lock_async = 1'b1;
    cyc(4);
    lock_async = 1'b0;
    cyc(5);
    rd(2'd1, 32'h1, 7);
    chk(7, {31'd0, irq_o}, 32'h0);
    wr(2'd3, 32'h1);
    rd(2'd1, 32'h0, 6);

    // R5: loss of lock while power is off is not flagged
    pwr_on = 1'b0;
    cyc(1);
    lock_async = 1'b1;
    cyc(4);
    lock_async = 1'b0;
    cyc(5);
    rd(2'd1, 32'h0, 5);

    // R2: writable again after power off
    wr(2'd0, 32'h0000_002A);
    rd(2'd0, 32'h0000_002A, 2);
    chk(2, {26'd0, mult_o}, 32'h2A);
    chk(2, {31'd0, range_hi_o}, 32'h0);

    cyc(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule